// File: doc/BRIEF.md
# Read Response Sequencer

This block sits on the external-agent side of a processor system bus and returns data for a read the processor has issued. It captures the read request (single word or full cache line, coherent or not, with or without a pending write that must come first), waits until the processor has voluntarily handed the bus over, then pulls beats from a local data source and drives them out as data cycles. Each cycle carries an identifier that marks it as response data. The identifier also flags the final beat, forwards a per-beat error flag, and for coherent line reads carries the cache state.

When the final beat has gone out, the block stops driving so the processor can take the bus back. Alongside the data path it watches the ordering rules of the response. It pulses an error output when the data source tries to start a response that is not allowed yet. A second error output pulses when a coherent line response carries a cache state that is illegal or that changes partway through the line.

Top module: `rrsp_gen`

## Requirements
- R1: After reset, `rsp_valid`, `bus_drive`, `rd_pending`, `proto_err`, `state_err` and `src_ready` are all low.
- R2: A beat is taken from the source (`src_ready` high) only while a read is pending; a pending read is set by `req_valid` and cleared after its final beat.
- R3: Every response beat has `rsp_id[5]` (response-data flag) set. `rsp_id[4]` (last flag) is set on the final beat only. The beat appears on `rsp_valid`/`rsp_data`/`rsp_id` in the cycle after the source hand-off.
- R4: A word read (`req_block`=0) yields exactly one beat. A line read (`req_block`=1) yields exactly `LINE_BEATS` beats (default 4).
- R5: For a coherent line read, `rsp_id[2:0]` carries `src_state`. For every other read it is 0. State codes: 1 shared, 2 dirty shared, 3 clean exclusive, 4 dirty exclusive, and all other values are illegal.
- R6: `rsp_id[3]` copies the beat's `src_err`, and an erroneous beat does not shorten the line.
- R7: `src_valid` while no read is pending causes a one-cycle `proto_err` pulse in the next cycle, and no beat is taken.
- R8: For a read flagged `req_wforth`, no beat is taken until `wr_accept` has been seen in an earlier cycle. A `src_valid` before that gives a `proto_err` pulse in the next cycle.
- R9: `bus_drive` is high from the first beat cycle through the final beat cycle. In the cycle after the final beat, both `bus_drive` and `rd_pending` are low.
- R10: While `slave_mode` is low, no beat is taken and a waiting `src_valid` raises no error.
- R11: For a coherent line read, `state_err` pulses with each beat whose state is illegal, or whose state differs from the first beat's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Captured processor read request, one-cycle strobe |
| req_block | input | 1 | 1: line read, 0: word read |
| req_coh | input | 1 | Coherent read |
| req_wforth | input | 1 | A write must be accepted before the response |
| wr_accept | input | 1 | Processor write or null write accepted |
| slave_mode | input | 1 | Processor has handed the bus to the agent |
| src_valid | input | 1 | Local source offers a beat |
| src_data | input | DATA_W | Beat data |
| src_err | input | 1 | Beat is erroneous |
| src_state | input | 3 | Cache state for the beat |
| src_ready | output | 1 | Beat is taken this cycle |
| rsp_valid | output | 1 | Response data cycle |
| rsp_id | output | 6 | Identifier: [5] response, [4] last, [3] error, [2:0] state |
| rsp_data | output | DATA_W | Response data |
| bus_drive | output | 1 | Agent drives command and data buses |
| rd_pending | output | 1 | A read awaits its response |
| proto_err | output | 1 | Ordering violation pulse |
| state_err | output | 1 | Cache state violation pulse |

## Verification
The hardest case to reach is a write-forthcoming read where the source is eager. The source must offer data after the bus is handed over, but before the write has been accepted. That offer must be refused and flagged, and the beat must then go through once the write lands. The stimulus reaches this by issuing such a request with `slave_mode` already high, offering a beat for one cycle, and pulsing `wr_accept` only afterwards. A second hard case is a source that stalls while `slave_mode` is low. It is reached by holding `src_valid` high across several cycles with the hand-over withheld, which must give neither beats nor errors.

// File: rtl/rrsp_pkg.sv
package rrsp_pkg;

  localparam int unsigned CST_W = 3;
  localparam int unsigned ID_W  = 6;

  typedef enum logic [CST_W-1:0] {
    CST_INVALID = 3'd0,
    CST_SHARED  = 3'd1,
    CST_DSHARED = 3'd2,
    CST_CEXCL   = 3'd3,
    CST_DEXCL   = 3'd4
  } cst_e;

  // Identifier layout: bit 5 response, bit 4 last, bit 3 error, bits 2:0 state
  typedef struct packed {
    logic             resp;
    logic             last;
    logic             err;
    logic [CST_W-1:0] cst;
  } rsp_id_t;

  function automatic logic cst_legal(input logic [CST_W-1:0] s);
    return (s == CST_SHARED) || (s == CST_DSHARED) ||
           (s == CST_CEXCL)  || (s == CST_DEXCL);
  endfunction

endpackage

// File: rtl/rrsp_tracker.sv
// Holds the pending read, the write-forthcoming gate and the ordering check.
module rrsp_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_block,
  input  logic req_coh,
  input  logic req_wforth,
  input  logic wr_accept,
  input  logic slave_mode,
  input  logic src_valid,
  input  logic done,
  output logic pend,
  output logic blk,
  output logic coh,
  output logic take_ok,
  output logic proto_err
);

  logic wf_q, wseen_q;
  logic pend_n, wseen_n;
  logic cap_en, bad_attempt;

  assign cap_en = req_valid && !pend && !done;

  always_comb begin
    pend_n = pend;
    if (done)        pend_n = 1'b0;
    else if (cap_en) pend_n = 1'b1;
  end

  always_comb begin
    wseen_n = wseen_q;
    if (done || cap_en)       wseen_n = 1'b0;
    else if (pend && wr_accept) wseen_n = 1'b1;
  end

  assign take_ok     = pend && slave_mode && (!wf_q || wseen_q);
  assign bad_attempt = src_valid && (!pend || (wf_q && !wseen_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      wseen_q   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      pend      <= pend_n;
      wseen_q   <= wseen_n;
      proto_err <= bad_attempt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk  <= 1'b0;
      coh  <= 1'b0;
      wf_q <= 1'b0;
    end else if (cap_en) begin
      blk  <= req_block;
      coh  <= req_coh;
      wf_q <= req_wforth;
    end
  end

endmodule

// File: rtl/rrsp_beat_ctr.sv
// Counts beats handed off in the current response and marks the final one.
module rrsp_beat_ctr #(
  parameter int unsigned LINE_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic blk,
  output logic first,
  output logic last
);

  localparam int unsigned CNT_W = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LINE_BEATS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign first = (cnt_q == '0);
  assign last  = !blk || (cnt_q == CNT_END);

  always_comb begin
    cnt_n = cnt_q;
    if (take) begin
      if (last) cnt_n = '0;
      else      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (take) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/rrsp_state_mon.sv
// Checks that a coherent line keeps one legal cache state on every beat.
module rrsp_state_mon
  import rrsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             coh_blk,
  input  logic             first,
  input  logic [CST_W-1:0] st,
  output logic             state_err
);

  logic [CST_W-1:0] held_q;
  logic             bad;
  logic             hold_en;

  assign hold_en = take && first;
  assign bad = take && coh_blk &&
               (!cst_legal(st) || (!first && (st != held_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (hold_en) held_q <= st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_err <= 1'b0;
    else        state_err <= bad;
  end

endmodule

// File: rtl/rrsp_gen.sv
module rrsp_gen
  import rrsp_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_block,
  input  logic              req_coh,
  input  logic              req_wforth,
  input  logic              wr_accept,
  input  logic              slave_mode,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_err,
  input  logic [2:0]        src_state,
  output logic              src_ready,
  output logic              rsp_valid,
  output logic [5:0]        rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_drive,
  output logic              rd_pending,
  output logic              proto_err,
  output logic              state_err
);

  logic    pend, blk, coh, take_ok;
  logic    take, first, last, done;
  logic    drive_n;
  rsp_id_t id_n, id_q;

  rrsp_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_block  (req_block),
    .req_coh    (req_coh),
    .req_wforth (req_wforth),
    .wr_accept  (wr_accept),
    .slave_mode (slave_mode),
    .src_valid  (src_valid),
    .done       (done),
    .pend       (pend),
    .blk        (blk),
    .coh        (coh),
    .take_ok    (take_ok),
    .proto_err  (proto_err)
  );

  assign take = src_valid && take_ok;
  assign done = take && last;

  rrsp_beat_ctr #(.LINE_BEATS(LINE_BEATS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .blk   (blk),
    .first (first),
    .last  (last)
  );

  rrsp_state_mon u_smon (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .coh_blk   (coh && blk),
    .first     (first),
    .st        (src_state),
    .state_err (state_err)
  );

  always_comb begin
    id_n.resp = 1'b1;
    id_n.last = last;
    id_n.err  = src_err;
    id_n.cst  = (coh && blk) ? src_state : '0;
  end

  always_comb begin
    drive_n = bus_drive;
    if (take)                         drive_n = 1'b1;
    else if (rsp_valid && id_q.last)  drive_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bus_drive <= 1'b0;
    end else begin
      rsp_valid <= take;
      bus_drive <= drive_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      rsp_data <= '0;
    end else if (take) begin
      id_q     <= id_n;
      rsp_data <= src_data;
    end
  end

  assign rsp_id     = id_q;
  assign src_ready  = take_ok;
  assign rd_pending = pend;

endmodule

// File: rtl/rrsp_gen_chk.sv
module rrsp_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slave_mode,
  input logic       src_valid,
  input logic       src_err,
  input logic       src_ready,
  input logic       rsp_valid,
  input logic [5:0] rsp_id,
  input logic       bus_drive,
  input logic       rd_pending,
  input logic       proto_err
);

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pending |-> !src_ready); // R2

  AST_RESP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_id[5]); // R3

  AST_ERR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> (rsp_valid && (rsp_id[3] == $past(src_err)))); // R6

  AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !rd_pending) |=> proto_err); // R7

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pending && slave_mode && src_valid && !src_ready) |=> proto_err); // R8

  AST_DRIVE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> bus_drive); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_id[4]) |=> (!bus_drive && !rd_pending)); // R9

  AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |-> !src_ready); // R10

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pending && !slave_mode && src_valid && !src_ready) |=> !rsp_valid); // R10

endmodule

bind rrsp_gen rrsp_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_mode (slave_mode),
  .src_valid  (src_valid),
  .src_err    (src_err),
  .src_ready  (src_ready),
  .rsp_valid  (rsp_valid),
  .rsp_id     (rsp_id),
  .bus_drive  (bus_drive),
  .rd_pending (rd_pending),
  .proto_err  (proto_err)
);

// File: tb/rrsp_gen_test.sv
`timescale 1ns/1ps
module rrsp_gen_test;

  localparam int DW = 32;
  localparam int LB = 4;

  logic          clk, rst_n;
  logic          req_valid, req_block, req_coh, req_wforth, wr_accept, slave_mode;
  logic          src_valid, src_err, src_ready;
  logic [DW-1:0] src_data, rsp_data;
  logic [2:0]    src_state;
  logic          rsp_valid, bus_drive, rd_pending, proto_err, state_err;
  logic [5:0]    rsp_id;

  rrsp_gen #(.DATA_W(DW), .LINE_BEATS(LB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .req_coh(req_coh), .req_wforth(req_wforth), .wr_accept(wr_accept),
    .slave_mode(slave_mode), .src_valid(src_valid), .src_data(src_data),
    .src_err(src_err), .src_state(src_state), .src_ready(src_ready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .bus_drive(bus_drive), .rd_pending(rd_pending), .proto_err(proto_err),
    .state_err(state_err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp, n_bad, n_beats, n_proto, n_state;
  bit mon_on, rel_chk, done_flag;
  logic [37:0] expq[$];

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected beats and checks bus release
  always @(negedge clk) begin
    if (mon_on) begin
      if (proto_err) n_proto++;
      if (state_err) n_state++;
      if (rel_chk) begin
        chk(!bus_drive && !rd_pending, "R9 release after last beat", {bus_drive, rd_pending}, 0);
        rel_chk = 1'b0;
      end
      if (rsp_valid) begin
        n_beats++;
        chk(bus_drive, "R9 drive during beat", bus_drive, 1);
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected beat", {rsp_id, rsp_data}, 0);
        end else begin
          logic [37:0] e;
          e = expq.pop_front();
          chk({rsp_id, rsp_data} == e, "R3/R5/R6 beat identifier and data", {rsp_id, rsp_data}, e);
        end
        if (rsp_id[4]) rel_chk = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic issue_req(input bit blk, input bit coh, input bit wf);
    @(negedge clk);
    req_valid = 1'b1; req_block = blk; req_coh = coh; req_wforth = wf;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Driver: offers one beat until taken, pushes the expected identifier/data
  task automatic push_beat(input logic [DW-1:0] d, input bit err, input logic [2:0] st,
                           input bit last, input bit cohblk);
    @(negedge clk);
    src_valid = 1'b1; src_data = d; src_err = err; src_state = st;
    #1;
    while (!src_ready) begin
      @(negedge clk); #1;
    end
    expq.push_back({1'b1, last, err, (cohblk ? st : 3'd0), d});
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  int b0, p0, s0;

  initial begin
    n_cmp = 0; n_bad = 0; n_beats = 0; n_proto = 0; n_state = 0;
    mon_on = 1'b0; rel_chk = 1'b0; done_flag = 1'b0;
    rst_n = 1'b0; req_valid = 0; req_block = 0; req_coh = 0; req_wforth = 0;
    wr_accept = 0; slave_mode = 1; src_valid = 0; src_data = '0; src_err = 0; src_state = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({rsp_valid, bus_drive, rd_pending, proto_err, state_err, src_ready} == 6'b0,
        "R1 reset outputs", {rsp_valid, bus_drive, rd_pending, proto_err, state_err, src_ready}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(!src_ready, "R2 no take while idle", src_ready, 0);

    // R4 word read: one beat, last flag set
    b0 = n_beats;
    issue_req(0, 0, 0);
    @(negedge clk);
    chk(rd_pending, "R2 pending after request", rd_pending, 1);
    push_beat(32'hA5A5_0001, 0, 3'd0, 1, 0);
    settle();
    chk(n_beats - b0 == 1, "R4 word read beat count", n_beats - b0, 1);

    // R6 non-coherent line with an erroneous beat and a gap; state field zero (R5)
    b0 = n_beats;
    issue_req(1, 0, 0);
    push_beat(32'h1000_0000, 0, 3'd2, 0, 0);
    push_beat(32'h1000_0001, 1, 3'd2, 0, 0);
    @(negedge clk);
    push_beat(32'h1000_0002, 0, 3'd2, 0, 0);
    push_beat(32'h1000_0003, 0, 3'd2, 1, 0);
    settle();
    chk(n_beats - b0 == LB, "R4 line beat count with error beat R6", n_beats - b0, LB);

    // R5/R11 coherent line, state changes on the third beat
    b0 = n_beats; s0 = n_state;
    issue_req(1, 1, 0);
    push_beat(32'h2000_0000, 0, 3'd3, 0, 1);
    push_beat(32'h2000_0001, 0, 3'd3, 0, 1);
    push_beat(32'h2000_0002, 0, 3'd4, 0, 1);
    push_beat(32'h2000_0003, 0, 3'd3, 1, 1);
    settle();
    chk(n_state - s0 == 1, "R11 state change flagged once", n_state - s0, 1);

    // R11 coherent line with the invalid state on every beat
    s0 = n_state;
    issue_req(1, 1, 0);
    for (int i = 0; i < LB; i++) push_beat(32'h3000_0000 + i, 0, 3'd0, i == LB - 1, 1);
    settle();
    chk(n_state - s0 == LB, "R11 invalid state flagged per beat", n_state - s0, LB);

    // R5 coherent word read: state field zero, no state check
    s0 = n_state;
    issue_req(0, 1, 0);
    push_beat(32'h3500_0000, 0, 3'd6, 1, 0);
    settle();
    chk(n_state == s0, "R5 coherent word read no state check", n_state - s0, 0);

    // R7 stray source beat with nothing pending
    b0 = n_beats; p0 = n_proto;
    @(negedge clk); src_valid = 1'b1; src_data = 32'hDEAD_0000;
    @(posedge clk); #1; src_valid = 1'b0;
    settle();
    chk(n_proto - p0 == 1, "R7 stray beat flagged", n_proto - p0, 1);
    chk(n_beats == b0, "R7 stray beat not forwarded", n_beats - b0, 0);

    // R8 write-forthcoming: early offer refused, then accepted after write
    p0 = n_proto; b0 = n_beats;
    issue_req(0, 0, 1);
    @(negedge clk); src_valid = 1'b1; src_data = 32'hBEEF_0000;
    #1;
    chk(!src_ready, "R8 no take before write", src_ready, 0);
    @(posedge clk); #1; src_valid = 1'b0;
    @(negedge clk); wr_accept = 1'b1;
    @(posedge clk); #1; wr_accept = 1'b0;
    settle();
    chk(n_proto - p0 == 1, "R8 early offer flagged", n_proto - p0, 1);
    chk(n_beats == b0, "R8 no beat before write", n_beats - b0, 0);
    push_beat(32'h4000_0000, 0, 3'd0, 1, 0);
    settle();
    chk(n_beats - b0 == 1, "R8 beat after write", n_beats - b0, 1);

    // R10 stall while the bus is not handed over
    p0 = n_proto; b0 = n_beats;
    slave_mode = 1'b0;
    issue_req(0, 0, 0);
    @(negedge clk); src_valid = 1'b1; src_data = 32'h5000_0000; src_err = 0;
    repeat (4) @(negedge clk);
    chk(n_beats == b0, "R10 no beat while stalled", n_beats - b0, 0);
    chk(n_proto == p0, "R10 no error while stalled", n_proto - p0, 0);
    src_valid = 1'b0;
    slave_mode = 1'b1;
    push_beat(32'h5000_0000, 0, 3'd0, 1, 0);
    settle();
    chk(n_beats - b0 == 1, "R10 beat after hand-over", n_beats - b0, 1);

    chk(expq.size() == 0, "R4 all expected beats seen", expq.size(), 0);
    finish_run();
  end

endmodule